// File: doc/BRIEF.md
# Per-Pin Configurable GPIO Controller

This block is a memory-mapped general-purpose I/O controller for up to 32 pads. It sits on a simple 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. Every pin owns a four-bit configuration word. That word turns on the pin's output path, its input path, its output buffer and its interrupt. Software reads all input levels as one word. It can load the output latch whole, or change single bits through a set register and a clear register, each of which acts only on the data bits written as one. This avoids read-modify-write races between software agents.

The number of implemented pins is the parameter `NUM_PINS`, intended to be 14, 24 or 32. Pad inputs pass through a two-flop synchronizer. An interrupt line rises while any interrupt-enabled pin has a high synchronized input. The block has no state machine. Bus accesses are classified each cycle by an address decoder into one of six access kinds: none, configuration, input, latch, set and clear. A `unique case` on that kind steers writes into the configuration bank or the output latch, and selects the read data.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every configuration word, the output latch, `pad_out`, `pad_oe`, `irq` and `bus_rdata` are zero.
- R2: A write to byte offset 4*i, for i below `NUM_PINS`, stores `bus_wdata[3:0]` as pin i's configuration. The bits are: bit 0 output enable, bit 1 input enable, bit 2 output-buffer enable, bit 3 interrupt enable. A read of that offset returns those four bits with bits 31:4 zero.
- R3: A read of offset 0x084 returns, at bit n, the level `pad_in[n]` had two clock edges earlier, when pin n's input enable is set. The bit reads 0 when that enable is clear.
- R4: A write to offset 0x088 loads the output latch with the low `NUM_PINS` bits of `bus_wdata`. A read of 0x088 returns the latch.
- R5: A write to offset 0x0A4 sets each latch bit whose data bit is 1 and leaves the others unchanged.
- R6: A write to offset 0x0A0 clears each latch bit whose data bit is 1 and leaves the others unchanged.
- R7: `pad_oe[i]` is 1 exactly when pin i has both output enable (bit 0) and output-buffer enable (bit 2) set.
- R8: `pad_out` always equals the output latch.
- R9: `irq` is 1 exactly when some pin has interrupt enable (bit 3) set and a high synchronized input. The input enable plays no part in this.
- R10: Writes have no effect, and reads return 0, when they go to configuration words of pins at or above `NUM_PINS`, to unmapped offsets, or to unaligned addresses. The set and clear offsets read as 0. Latch bits at or above `NUM_PINS` read as 0.
- R11: `bus_rdata` shows the read value one cycle after a cycle with `bus_re` high. It is 0 one cycle after a cycle with `bus_re` low. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output levels to the pads |
| pad_oe | output | NUM_PINS | Per-pin drive enable, 1 drives the pad |
| irq | output | 1 | Level interrupt request |

## Verification
A configuration write that changes a pin's interrupt enable can land on the same clock edge at which that pin's synchronized input rises. The bench provokes this by raising a pad input and issuing the configuration write so that it is sampled exactly at the second synchronizer edge. This is done once to disable the interrupt and once to enable it. `irq` must then never pulse in the first case and must rise on that very edge in the second. A behavioural model, updated on each edge, also judges the long random phase, where writes, reads and pad changes collide freely.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned OFF_INPUT = 'h084;
    localparam int unsigned OFF_LATCH = 'h088;
    localparam int unsigned OFF_CLEAR = 'h0A0;
    localparam int unsigned OFF_SET   = 'h0A4;
    localparam int unsigned CFG_BITS  = 4;

    typedef struct packed {
        logic irq_en;   // bit 3
        logic buf_en;   // bit 2
        logic in_en;    // bit 1
        logic out_en;   // bit 0
    } pin_cfg_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_INPUT,
        ACC_LATCH,
        ACC_SET,
        ACC_CLEAR
    } acc_kind_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int WORD_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_t         kind,
    output logic [IDX_W-1:0]  idx
);
    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = word[IDX_W-1:0];

    always_comb begin
        kind = ACC_NONE;
        if (aligned) begin
            if (word < WORD_W'(NUM_PINS))                 kind = ACC_CFG;
            else if (word == WORD_W'(OFF_INPUT >> 2))     kind = ACC_INPUT;
            else if (word == WORD_W'(OFF_LATCH >> 2))     kind = ACC_LATCH;
            else if (word == WORD_W'(OFF_SET >> 2))       kind = ACC_SET;
            else if (word == WORD_W'(OFF_CLEAR >> 2))     kind = ACC_CLEAR;
        end
    end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  pin_cfg_t                wr_cfg,
    output pin_cfg_t [NUM_PINS-1:0] cfg_q
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                cfg_q[i] <= wr_cfg;
            end
        end
    end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  acc_kind_t           kind,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            unique case (kind)
                ACC_LATCH: q <= wdata;
                ACC_SET:   q <= q | wdata;
                ACC_CLEAR: q <= q & ~wdata;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_re,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    acc_kind_t               kind;
    logic [IDX_W-1:0]        idx;
    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    logic [NUM_PINS-1:0]     sync_q;
    logic [NUM_PINS-1:0]     latch_q;
    logic [NUM_PINS-1:0]     in_en_vec;
    logic [NUM_PINS-1:0]     irq_en_vec;
    logic [31:0]             rd_val;

    gpio_addr_dec #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    gpio_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_we && (kind == ACC_CFG)),
        .wr_idx (idx),
        .wr_cfg (pin_cfg_t'(bus_wdata[CFG_BITS-1:0])),
        .cfg_q  (cfg_q)
    );

    gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .kind  (kind),
        .wdata (bus_wdata[NUM_PINS-1:0]),
        .q     (latch_q)
    );

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        assign pad_oe[i]     = cfg_q[i].out_en & cfg_q[i].buf_en;
        assign in_en_vec[i]  = cfg_q[i].in_en;
        assign irq_en_vec[i] = cfg_q[i].irq_en;
    end

    assign pad_out = latch_q;
    assign irq     = |(sync_q & irq_en_vec);

    always_comb begin
        unique case (kind)
            ACC_CFG:   rd_val = 32'(cfg_q[idx]);
            ACC_INPUT: rd_val = 32'(sync_q & in_en_vec);
            ACC_LATCH: rd_val = 32'(latch_q);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_re ? rd_val : '0;
        end
    end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [31:0]         bus_wdata,
    input logic                bus_re,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] ie_mask
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   word;
    logic                aligned, cfg_wr, lat_wr, set_wr, clr_wr;
    logic [31:0]         oe_wide;
    logic [NUM_PINS-1:0] wd;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign cfg_wr  = bus_we && aligned && (word < WORD_W'(NUM_PINS));
    assign lat_wr  = bus_we && aligned && (word == WORD_W'(OFF_LATCH >> 2));
    assign set_wr  = bus_we && aligned && (word == WORD_W'(OFF_SET >> 2));
    assign clr_wr  = bus_we && aligned && (word == WORD_W'(OFF_CLEAR >> 2));
    assign oe_wide = 32'(pad_oe);
    assign wd      = bus_wdata[NUM_PINS-1:0];

    a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        lat_wr |=> (pad_out == $past(wd)));

    a_r5_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((pad_out & $past(wd)) == $past(wd)));

    a_r5_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((pad_out & ~$past(wd)) == ($past(pad_out) & ~$past(wd))));

    a_r6_clr_hits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((pad_out & $past(wd)) == '0));

    a_r6_clr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((pad_out & ~$past(wd)) == ($past(pad_out) & ~$past(wd))));

    a_r7_oe_follows_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && bus_wdata[0] && bus_wdata[2]) |=> oe_wide[$past(word[4:0])]);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_mask != '0));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .ie_mask   (irq_en_vec)
);

// File: tb/gpio_ctrl_tb_top.sv
module gpio_ctrl_tb_top;
    localparam int N = 24;
    localparam logic [31:0] MASK = 32'((64'h1 << N) - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_re = 1'b0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // behavioural reference state
    logic [3:0]  m_cfg [32];
    logic [31:0] m_latch, m_s1, m_s2, m_rd;

    always #10 clk = ~clk;

    gpio_ctrl #(.NUM_PINS(N), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bitmask(input int b);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < N; i++) if (m_cfg[i][b]) r[i] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_cfg[i] = '0;
            m_latch = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
        end else begin
            int w;
            logic [31:0] rd;
            logic al;
            w  = int'(bus_addr[11:2]);
            al = (bus_addr[1:0] == 2'b00);
            rd = '0;
            if (bus_re && al) begin
                if (w < N)        rd = {28'h0, m_cfg[w]};
                else if (w == 33) rd = m_s2 & bitmask(1);
                else if (w == 34) rd = m_latch;
            end
            if (bus_we && al) begin
                if (w < N)        m_cfg[w] = bus_wdata[3:0];
                else if (w == 34) m_latch = bus_wdata & MASK;
                else if (w == 41) m_latch = m_latch | (bus_wdata & MASK);
                else if (w == 40) m_latch = m_latch & ~(bus_wdata & MASK);
            end
            m_s2 = m_s1;
            m_s1 = 32'(pad_in);
            m_rd = rd;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R8 pad_out vs model", 32'(pad_out), m_latch);
            chk("R7 pad_oe vs model", 32'(pad_oe), bitmask(0) & bitmask(2));
            chk("R9 irq vs model", 32'(irq), 32'(|(m_s2 & bitmask(3))));
            chk("R11 bus_rdata vs model", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 bus_rdata", bus_rdata, 32'h0);
        rd(12'h000, 32'h0, "R1 cfg0 after reset");
        rd(12'h088, 32'h0, "R1 latch after reset");
        // R2 / R7
        wr(12'h00C, 32'hFFFF_FFF5);
        rd(12'h00C, 32'h5, "R2 cfg3 upper bits dropped");
        chk("R7 pad_oe[3] with out+buf", 32'(pad_oe[3]), 32'h1);
        wr(12'h00C, 32'h1);
        chk("R7 pad_oe[3] without buf", 32'(pad_oe[3]), 32'h0);
        rd(12'h00C, 32'h1, "R2 cfg3 rewrite");
        // R4 / R8 / R5 / R6
        wr(12'h088, 32'h00A5_A5A5);
        rd(12'h088, 32'h00A5_A5A5, "R4 latch load");
        chk("R8 pad_out equals latch", 32'(pad_out), 32'h00A5_A5A5);
        wr(12'h0A4, 32'h0000_0F00);
        rd(12'h088, 32'h00A5_AFA5, "R5 set bits");
        wr(12'h0A0, 32'h0000_00A5);
        rd(12'h088, 32'h00A5_AF00, "R6 clear bits");
        rd(12'h0A4, 32'h0, "R10 set register reads zero");
        // R10
        wr(12'h088, 32'hFFFF_FFFF);
        rd(12'h088, 32'h00FF_FFFF, "R10 latch bits above pin count");
        wr(12'h078, 32'hF);
        rd(12'h078, 32'h0, "R10 config beyond pin count");
        rd(12'h090, 32'h0, "R10 unmapped offset");
        wr(12'h00D, 32'hF);
        rd(12'h00C, 32'h1, "R10 unaligned write ignored");
        // R3
        wr(12'h008, 32'h2);
        @(negedge clk); pad_in = 24'h000014;
        repeat (3) @(negedge clk);
        rd(12'h084, 32'h4, "R3 input word with enable mask");
        @(negedge clk);
        chk("R11 rdata zero after idle", bus_rdata, 32'h0);
        // R9: interrupt disabled on the edge where the input rises
        wr(12'h014, 32'hA);
        @(negedge clk); pad_in[5] = 1'b1;
        @(negedge clk); bus_addr = 12'h014; bus_wdata = 32'h2; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        chk("R9 irq stays low when disabled on same edge", 32'(irq), 32'h0);
        // R9: interrupt enabled on the edge where the input rises
        @(negedge clk); pad_in[5] = 1'b0;
        repeat (3) @(negedge clk);
        pad_in[5] = 1'b1;
        @(negedge clk); bus_addr = 12'h014; bus_wdata = 32'hA; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        chk("R9 irq rises when enabled on same edge", 32'(irq), 32'h1);
        // random phase against the model
        for (int k = 0; k < 3000; k++) begin
            int sel;
            @(negedge clk);
            sel = $urandom_range(0, 8);
            case (sel)
                0, 1, 2, 3: bus_addr = 12'($urandom_range(0, 31) * 4);
                4: bus_addr = 12'h084;
                5: bus_addr = 12'h088;
                6: bus_addr = 12'h0A4;
                7: bus_addr = 12'h0A0;
                default: bus_addr = 12'($urandom);
            endcase
            bus_we = 1'($urandom);
            bus_re = 1'($urandom);
            bus_wdata = $urandom;
            if ($urandom_range(0, 3) == 0) pad_in = N'($urandom);
        end
        @(negedge clk); bus_we = 1'b0; bus_re = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule